// File: doc/BRIEF.md
# Nonvolatile Store Protection Controller

This block decides when the contents of a 16-word shadow RAM may be copied into nonvolatile storage. It takes single-cycle command pulses that have already been decoded by a serial front end. It also takes an active-low hardware store pin and a hardware recall request. Two internal latches act as the safeguard: a write-enable latch and a previous-recall latch.

A store starts only when a store request arrives while both latches are set. The controller then holds a busy output high for a fixed, parameterized number of clock cycles. While busy is high, every other command is inhibited. When the cycle ends, the write-enable latch clears itself, so a further store or RAM write needs a fresh enable.

The block also drives the write-permit signal used by the RAM write path. It issues a one-cycle recall-start pulse whenever it accepts a recall.

Top module: `nvs_store_guard`

## Requirements
- R1: After reset, the write-enable flag, the recall flag, busy, write_permit, store_start and recall_start are all 0.
- R2: While idle, a wren_cmd pulse sets the write-enable flag and a wrds_cmd pulse clears it; the flag changes at the clock edge that samples the pulse. If both pulses arrive in the same cycle, the flag is cleared.
- R3: write_permit is 1 exactly when the write-enable flag is 1 and busy is 0.
- R4: A store request (store_cmd pulse, or a falling edge on store_pin_n) is accepted only if busy is 0 and both flags are 1. On acceptance, busy and a one-cycle store_start pulse rise at the next clock edge.
- R5: A store request that is not accepted leaves no pending state. Setting the missing flag afterwards does not start a store.
- R6: Once raised, busy stays high for exactly STORE_CYCLES consecutive cycles (16 by default).
- R7: The clock edge that lowers busy also clears the write-enable flag.
- R8: While busy is 1, wren_cmd, wrds_cmd, recall_cmd, hw_recall and store requests have no effect on the flags, recall_start or the timer.
- R9: A recall_cmd or hw_recall pulse while idle sets the recall flag and gives a one-cycle recall_start pulse at the next clock edge. Only reset clears the recall flag.
- R10: store_pin_n passes through SYNC_STAGES synchronizer flops and is edge-detected. A single low period, however long, triggers at most one store. A later store needs the pin to return high and then fall again.
- R11: The guard uses the flag values held before the current cycle. If a store is accepted in a cycle, any wren, wrds or recall pulse in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_cmd | input | 1 | Decoded write-enable command pulse |
| wrds_cmd | input | 1 | Decoded write-disable command pulse |
| store_cmd | input | 1 | Decoded store command pulse |
| recall_cmd | input | 1 | Decoded recall command pulse |
| store_pin_n | input | 1 | Asynchronous active-low hardware store pin |
| hw_recall | input | 1 | Hardware recall request pulse |
| busy | output | 1 | High for the duration of a store cycle |
| write_permit | output | 1 | RAM writes allowed |
| store_start | output | 1 | One-cycle pulse at the start of a store cycle |
| recall_start | output | 1 | One-cycle pulse when a recall is accepted |
| wel_flag | output | 1 | Write-enable latch state |
| prl_flag | output | 1 | Previous-recall latch state |

## Verification
Store acceptance is the function most likely to collide with the others. In one cycle, a store request can meet a write-disable, a write-enable or a recall pulse, and those pulses would otherwise change the very latches the guard reads. The bench drives store, recall and write-disable together while both flags are set, and expects the store to win: busy rises, no recall_start appears, and the write-enable flag holds until the cycle ends. It also drives a recall and a store together while the recall flag is still clear, and expects the recall to take effect and the store to be dropped.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   // Decoded command set presented to the latch logic in one cycle
   typedef struct packed {
      logic wren;
      logic wrds;
      logic recall;
   } nvs_cmd_t;

   // Minimum synchronizer depth accepted by the pin front end
   localparam int unsigned NVS_MIN_SYNC = 2;

   function automatic int unsigned nvs_cnt_width(input int unsigned cycles);
      return (cycles < 2) ? 1 : $clog2(cycles);
   endfunction

endpackage

// File: rtl/nvs_pin_edge.sv
module nvs_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);
   import nvs_pkg::*;

   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [LAST:0] sync_q;
   logic          prev_q;

   generate
      if (SYNC_STAGES < NVS_MIN_SYNC) begin : g_bad_depth
         $error("nvs_pin_edge: SYNC_STAGES below minimum");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= pin_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b1;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[LAST];
   end

   assign fall = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/nvs_store_timer.sv
module nvs_store_timer #(
   parameter int unsigned STORE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic done,
   output logic start_pulse
);
   import nvs_pkg::*;

   localparam int unsigned CNT_W = nvs_cnt_width(STORE_CYCLES);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STORE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             start_q;

   generate
      if (STORE_CYCLES < 1) begin : g_bad_len
         $error("nvs_store_timer: STORE_CYCLES must be at least 1");
      end
   endgenerate

   assign done = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end else if (launch) begin
            busy_q  <= 1'b1;
            cnt_q   <= LOAD;
            start_q <= 1'b1;
         end
      end
   end

   assign busy        = busy_q;
   assign start_pulse = start_q;

endmodule

// File: rtl/nvs_guard_latches.sv
module nvs_guard_latches
   import nvs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  nvs_cmd_t cmd,
   input  logic     busy,
   input  logic     done,
   input  logic     launch,
   output logic     wel,
   output logic     prl,
   output logic     recall_pulse
);

   logic wel_q, prl_q, rcl_q;
   logic idle_free;

   // Commands only act when no store is running or being launched
   assign idle_free = ~busy & ~launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (done) begin
         wel_q <= 1'b0;
      end else if (idle_free) begin
         if (cmd.wrds)      wel_q <= 1'b0;
         else if (cmd.wren) wel_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prl_q <= 1'b0;
         rcl_q <= 1'b0;
      end else begin
         rcl_q <= idle_free & cmd.recall;
         if (idle_free & cmd.recall) prl_q <= 1'b1;
      end
   end

   assign wel          = wel_q;
   assign prl          = prl_q;
   assign recall_pulse = rcl_q;

endmodule

// File: rtl/nvs_store_guard.sv
module nvs_store_guard
   import nvs_pkg::*;
#(
   parameter int unsigned STORE_CYCLES = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wren_cmd,
   input  logic wrds_cmd,
   input  logic store_cmd,
   input  logic recall_cmd,
   input  logic store_pin_n,
   input  logic hw_recall,
   output logic busy,
   output logic write_permit,
   output logic store_start,
   output logic recall_start,
   output logic wel_flag,
   output logic prl_flag
);

   nvs_cmd_t cmd;
   logic     pin_fall;
   logic     store_req;
   logic     launch;
   logic     busy_i, done_i, wel_i, prl_i;

   nvs_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (store_pin_n),
      .fall  (pin_fall)
   );

   assign cmd.wren   = wren_cmd;
   assign cmd.wrds   = wrds_cmd;
   assign cmd.recall = recall_cmd | hw_recall;

   assign store_req = store_cmd | pin_fall;
   assign launch    = store_req & ~busy_i & wel_i & prl_i;

   nvs_store_timer #(.STORE_CYCLES(STORE_CYCLES)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .busy        (busy_i),
      .done        (done_i),
      .start_pulse (store_start)
   );

   nvs_guard_latches u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd          (cmd),
      .busy         (busy_i),
      .done         (done_i),
      .launch       (launch),
      .wel          (wel_i),
      .prl          (prl_i),
      .recall_pulse (recall_start)
   );

   assign busy         = busy_i;
   assign wel_flag     = wel_i;
   assign prl_flag     = prl_i;
   assign write_permit = wel_i & ~busy_i;

endmodule

// File: rtl/nvs_store_guard_chk.sv
module nvs_store_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic write_permit,
   input logic store_start,
   input logic recall_start,
   input logic wel_flag,
   input logic prl_flag
);

   p_permit_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !write_permit);

   p_start_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(store_start) |-> (busy && $past(wel_flag) && $past(prl_flag) && !$past(busy)));

   p_end_clears_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel_flag);

   p_wel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wel_flag));

   p_no_recall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      recall_start |-> (prl_flag && !$past(busy)));

   p_prl_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prl_flag) |-> prl_flag);

   p_single_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_start && recall_start));

endmodule

bind nvs_store_guard nvs_store_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .write_permit (write_permit),
   .store_start  (store_start),
   .recall_start (recall_start),
   .wel_flag     (wel_flag),
   .prl_flag     (prl_flag)
);

// File: tb/nvs_store_guard_test.sv
`timescale 1ns/1ps
module nvs_store_guard_test;

   localparam int STORE_CYCLES = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wren_cmd = 0, wrds_cmd = 0, store_cmd = 0, recall_cmd = 0;
   logic store_pin_n = 1'b1, hw_recall = 1'b0;
   logic busy, write_permit, store_start, recall_start, wel_flag, prl_flag;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   nvs_store_guard #(.STORE_CYCLES(STORE_CYCLES), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .wren_cmd(wren_cmd), .wrds_cmd(wrds_cmd), .store_cmd(store_cmd),
      .recall_cmd(recall_cmd), .store_pin_n(store_pin_n), .hw_recall(hw_recall),
      .busy(busy), .write_permit(write_permit), .store_start(store_start),
      .recall_start(recall_start), .wel_flag(wel_flag), .prl_flag(prl_flag)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Drive a set of pulses for one cycle; outputs then reflect that edge
   task automatic issue(input logic en, input logic ds, input logic st,
                        input logic rc, input logic hr);
      wren_cmd = en; wrds_cmd = ds; store_cmd = st; recall_cmd = rc; hw_recall = hr;
      step();
      wren_cmd = 0; wrds_cmd = 0; store_cmd = 0; recall_cmd = 0; hw_recall = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && busy; i++) step();
   endtask

   task automatic t_reset();
      check("R1", wel_flag, 0, "wel after reset");
      check("R1", prl_flag, 0, "prl after reset");
      check("R1", busy, 0, "busy after reset");
      check("R1", write_permit, 0, "permit after reset");
      check("R1", store_start + recall_start, 0, "pulses after reset");
   endtask

   task automatic t_enable();
      issue(1, 0, 0, 0, 0);
      check("R2", wel_flag, 1, "wren sets");
      check("R3", write_permit, 1, "permit with wel");
      issue(0, 1, 0, 0, 0);
      check("R2", wel_flag, 0, "wrds clears");
      check("R3", write_permit, 0, "permit without wel");
      issue(1, 0, 0, 0, 0);
      issue(1, 1, 0, 0, 0);
      check("R2", wel_flag, 0, "wrds wins over wren");
   endtask

   task automatic t_blocked();
      issue(1, 0, 0, 0, 0);
      issue(0, 0, 1, 0, 0);
      check("R4", busy, 0, "store without recall flag");
      issue(0, 0, 0, 1, 0);
      check("R9", prl_flag, 1, "recall cmd sets prl");
      check("R9", recall_start, 1, "recall_start pulse");
      step();
      check("R9", recall_start, 0, "recall_start one cycle");
      check("R5", busy, 0, "dropped request not pending");
      issue(0, 1, 0, 0, 0);
      issue(0, 0, 1, 0, 0);
      check("R4", busy, 0, "store without wel");
      check("R9", prl_flag, 1, "prl kept after wrds");
      issue(1, 0, 0, 0, 0);
      step();
      check("R5", busy + store_start, 0, "no late store after wren");
   endtask

   task automatic t_store_cmd();
      int cnt;
      issue(0, 0, 1, 0, 0);
      check("R4", busy, 1, "store accepted");
      check("R4", store_start, 1, "store_start pulse");
      check("R3", write_permit, 0, "permit low while busy");
      cnt = 1;
      issue(0, 1, 0, 0, 1);
      if (busy) cnt++;
      check("R4", store_start, 0, "store_start one cycle");
      check("R8", wel_flag, 1, "wrds ignored while busy");
      check("R8", recall_start, 0, "hw recall ignored while busy");
      for (int i = 0; i < 100 && busy; i++) begin
         step();
         if (busy) cnt++;
      end
      check("R6", cnt, STORE_CYCLES, "busy length");
      check("R7", wel_flag, 0, "wel cleared at end");
      check("R3", write_permit, 0, "permit after store");
   endtask

   task automatic t_pin();
      int starts = 0;
      issue(1, 0, 0, 0, 0);
      store_pin_n = 1'b0;
      for (int i = 0; i < STORE_CYCLES + 40; i++) begin
         step();
         if (store_start) starts++;
         if (i == STORE_CYCLES + 10) issue(1, 0, 0, 0, 0);
      end
      check("R10", starts, 1, "one store per low period");
      check("R10", busy, 0, "held-low pin no restart");
      check("R10", wel_flag, 1, "wel re-armed while pin low");
      store_pin_n = 1'b1;
      repeat (4) step();
      store_pin_n = 1'b0;
      starts = 0;
      for (int i = 0; i < 8; i++) begin
         step();
         if (store_start) starts++;
      end
      check("R10", starts, 1, "second fall starts store");
      store_pin_n = 1'b1;
      wait_idle();
   endtask

   task automatic t_collide();
      issue(1, 0, 0, 0, 0);
      issue(0, 1, 1, 1, 0);
      check("R11", busy, 1, "store wins collision");
      check("R11", recall_start, 0, "recall dropped in collision");
      check("R11", wel_flag, 1, "wrds dropped in collision");
      wait_idle();
      check("R7", wel_flag, 0, "wel cleared after collision store");
   endtask

   task automatic t_fresh_recall();
      // Reset so recall flag is clear, then store+recall together
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
      check("R1", prl_flag, 0, "prl clear after second reset");
      issue(1, 0, 0, 0, 0);
      issue(0, 0, 1, 0, 1);
      check("R11", busy, 0, "store uses old prl");
      check("R9", prl_flag, 1, "hw recall sets prl");
      check("R9", recall_start, 1, "hw recall pulse");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable();
      t_blocked();
      t_store_cmd();
      t_pin();
      t_collide();
      t_fresh_recall();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule